// File: doc/BRIEF.md
# Machine Security Configuration Register

This block holds the machine-mode security configuration control/status register for an enhanced physical memory protection scheme. It keeps three control bits: a lockdown mode, a whitelist policy for machine-mode accesses, and a rule-lock bypass. The protection checker uses these bits directly from the block's outputs. Software reaches them through a simple CSR read/write port. The block decodes its own address, reports whether the access targets a defined register, and returns the read data combinationally.

Writes follow fixed legality rules. The lockdown and whitelist bits can be set but never cleared until reset. The bypass bit can be cleared at any time, but it can be raised from 0 to 1 only while none of the protection entries has its lock bit set. The per-entry lock bits arrive as an input vector. On 32-bit configurations a companion upper-half register also exists. It always reads as zero and ignores writes. Both registers exist only while the extension enable input is high.

Top module: `mach_seccfg_reg`

## Requirements
- R1: `csr_defined` is 1 only when `ext_en` is 1 and `csr_addr` is 0x747, or `csr_addr` is 0x757 with XLEN 32. Any other access is undefined, and `csr_rdata` is 0 for it.
- R2: A read of 0x747 places lockdown in bit 0, whitelist in bit 1 and bypass in bit 2. All higher bits read as 0, whatever was written to them.
- R3: The state changes only on a clock edge where `csr_we` is 1 and the access is a defined access to 0x747. A write to any other address leaves the state unchanged.
- R4: During a write cycle to 0x747, `csr_rdata` already shows the value the register will hold after that edge.
- R5: Once lockdown is 1, it stays 1 until reset. Writing 0 to bit 0 does not clear it.
- R6: Once whitelist is 1, it stays 1 until reset. Writing 0 to bit 1 does not clear it.
- R7: A write of 1 to bit 2 while bypass is 0 has no effect if any bit of `entry_lock` is 1. In every other case bypass takes write bit 2, including clearing it and rewriting 1 while it is already 1 with locks present.
- R8: Reset clears lockdown, whitelist and bypass, so a read of 0x747 returns 0.
- R9: The upper companion at 0x757 reads as 0 and ignores writes.
- R10: With `ext_en` low, writes to 0x747 leave all three bits unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_en | input | 1 | Extension enable; both registers exist only while high |
| csr_addr | input | 12 | CSR address of the current access |
| csr_we | input | 1 | Write strobe, committed on the rising clock edge |
| csr_wdata | input | XLEN | Write data |
| entry_lock | input | ENTRIES | Lock bit of each protection entry |
| csr_defined | output | 1 | The current address is an existing register |
| csr_rdata | output | XLEN | Read data, reflecting a write in the same cycle |
| lockdown | output | 1 | Machine-mode lockdown bit |
| whitelist | output | 1 | Machine-mode whitelist policy bit |
| bypass | output | 1 | Rule-lock bypass bit |

## Verification
The embedded assertions check several properties on every cycle. Lockdown and whitelist never fall. Bypass never rises after a cycle that had a locked entry. Nothing changes without a defined write. Undefined accesses read zero, and the unused high read bits stay zero. The directed scenarios cover behaviour that needs specific data values: the same-cycle write-through value, the gating of bypass by locks, rewriting bypass while locks are present, and the upper companion ignoring all-ones data.

// File: rtl/mach_seccfg_reg.sv
module mach_seccfg_reg #(
  parameter int          XLEN    = 32,
  parameter int          ENTRIES = 64,
  parameter logic [11:0] ADDR_LO = 12'h747,
  parameter logic [11:0] ADDR_HI = 12'h757
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ext_en,
  input  logic [11:0]        csr_addr,
  input  logic               csr_we,
  input  logic [XLEN-1:0]    csr_wdata,
  input  logic [ENTRIES-1:0] entry_lock,
  output logic               csr_defined,
  output logic [XLEN-1:0]    csr_rdata,
  output logic               lockdown,
  output logic               whitelist,
  output logic               bypass
);

  localparam bit HAS_HI = (XLEN == 32);

  logic hit_lo, hit_hi, wr, any_lock, byp_block;
  logic mml_q, mmwp_q, rlb_q;
  logic mml_d, mmwp_d, rlb_d;

  assign hit_lo    = ext_en && (csr_addr == ADDR_LO);
  assign hit_hi    = HAS_HI && ext_en && (csr_addr == ADDR_HI);
  assign wr        = csr_we && hit_lo;
  assign any_lock  = |entry_lock;
  assign byp_block = !rlb_q && csr_wdata[2] && any_lock;

  always_comb begin
    mml_d  = mml_q;
    mmwp_d = mmwp_q;
    rlb_d  = rlb_q;
    if (wr) begin
      mml_d  = mml_q  | csr_wdata[0];
      mmwp_d = mmwp_q | csr_wdata[1];
      rlb_d  = byp_block ? rlb_q : csr_wdata[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mml_q  <= 1'b0;
      mmwp_q <= 1'b0;
      rlb_q  <= 1'b0;
    end else begin
      mml_q  <= mml_d;
      mmwp_q <= mmwp_d;
      rlb_q  <= rlb_d;
    end
  end

  assign csr_defined = hit_lo || hit_hi;
  assign csr_rdata   = hit_lo ? {{(XLEN-3){1'b0}}, rlb_d, mmwp_d, mml_d} : '0;
  assign lockdown    = mml_q;
  assign whitelist   = mmwp_q;
  assign bypass      = rlb_q;

  // R5
  lockdown_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lockdown) |-> lockdown);

  // R6
  whitelist_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(whitelist) |-> whitelist);

  // R7
  bypass_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bypass) |-> $past(entry_lock == '0));

  // R3
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(csr_we && ext_en && csr_addr == ADDR_LO) |=> $stable({lockdown, whitelist, bypass}));

  // R1
  undef_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_defined |-> csr_rdata == '0);

  // R2
  high_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[XLEN-1:3] == '0);

endmodule

// File: tb/test_mach_seccfg_reg.sv
module test_mach_seccfg_reg;
  localparam int XLEN = 32;
  localparam int ENT  = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            ext_en = 1'b0;
  logic [11:0]     csr_addr = '0;
  logic            csr_we = 1'b0;
  logic [XLEN-1:0] csr_wdata = '0;
  logic [ENT-1:0]  entry_lock = '0;
  logic            csr_defined;
  logic [XLEN-1:0] csr_rdata;
  logic            lockdown, whitelist, bypass;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  mach_seccfg_reg #(.XLEN(XLEN), .ENTRIES(ENT)) i_mach_seccfg_reg (
    .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .csr_addr(csr_addr),
    .csr_we(csr_we), .csr_wdata(csr_wdata), .entry_lock(entry_lock),
    .csr_defined(csr_defined), .csr_rdata(csr_rdata),
    .lockdown(lockdown), .whitelist(whitelist), .bypass(bypass));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] state();
    return {29'd0, bypass, whitelist, lockdown};
  endfunction

  // drive a write at the falling edge, check same-cycle read, then state after edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string req,
                    input logic [31:0] exp_rd, input logic [31:0] exp_st);
    @(negedge clk);
    csr_addr = a; csr_wdata = d; csr_we = 1'b1;
    #1 chk({req, " rdata"}, csr_rdata, exp_rd);
    @(posedge clk); #1;
    csr_we = 1'b0;
    chk({req, " state"}, state(), exp_st);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    ext_en = 1'b1; csr_addr = 12'h747; #1;
    chk("R8 state", state(), 32'h0);
    chk("R8 read", csr_rdata, 32'h0);
    chk("R1 defined main", {31'd0, csr_defined}, 32'h1);
  endtask

  task automatic t_decode();
    @(negedge clk); csr_addr = 12'h757; #1;
    chk("R1 defined upper", {31'd0, csr_defined}, 32'h1);
    chk("R9 upper read", csr_rdata, 32'h0);
    csr_addr = 12'h300; #1;
    chk("R1 other addr", {31'd0, csr_defined}, 32'h0);
    ext_en = 1'b0; csr_addr = 12'h747; #1;
    chk("R1 disabled", {31'd0, csr_defined}, 32'h0);
    chk("R1 disabled rdata", csr_rdata, 32'h0);
  endtask

  task automatic t_ignored();
    ext_en = 1'b0;
    wr(12'h747, 32'h7, "R10 disabled write", 32'h0, 32'h0);
    ext_en = 1'b1;
    wr(12'h757, 32'hFFFF_FFFF, "R9 upper write", 32'h0, 32'h0);
    wr(12'h746, 32'h7, "R3 other addr write", 32'h0, 32'h0);
  endtask

  task automatic t_bypass();
    entry_lock = '0;
    wr(12'h747, 32'h4, "R4/R7 set unlocked", 32'h4, 32'h4);
    wr(12'h747, 32'h0, "R7 clear", 32'h0, 32'h0);
    entry_lock[37] = 1'b1;
    wr(12'h747, 32'h4, "R7 blocked by lock", 32'h0, 32'h0);
    entry_lock = '0;
    wr(12'h747, 32'h4, "R7 set again", 32'h4, 32'h4);
    entry_lock[63] = 1'b1;
    wr(12'h747, 32'h4, "R7 keep with lock", 32'h4, 32'h4);
    wr(12'h747, 32'h0, "R7 clear with lock", 32'h0, 32'h0);
    entry_lock = '0;
    wr(12'h747, 32'hFFFF_FFF8, "R2 high bits dropped", 32'h0, 32'h0);
  endtask

  task automatic t_sticky();
    wr(12'h747, 32'h1, "R5 set lockdown", 32'h1, 32'h1);
    wr(12'h747, 32'h0, "R5 lockdown sticky", 32'h1, 32'h1);
    wr(12'h747, 32'h2, "R6 set whitelist", 32'h3, 32'h3);
    wr(12'h747, 32'h4, "R6 both sticky", 32'h7, 32'h7);
    wr(12'h747, 32'h0, "R2 layout after clear", 32'h3, 32'h3);
    do_reset();
    #1 chk("R8 re-reset", state(), 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_decode();
    t_ignored();
    t_bypass();
    t_sticky();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule